// File: doc/BRIEF.md
# EDC Error Logging Registers

This block sits beside a 64-bit error-correction unit and records what the unit reports. It runs on its own diagnostic clock. On every edge of that clock it samples the unit's error flag, multiple-error flag, syndrome, check bits and read data word. From these it keeps three things: a 4-bit error count that stops at fifteen, a snapshot of the first error seen since the last diagnostic clear, and a running syndrome register that takes a new value on every edge.

A separate 16-bit mode register is loaded from the low half-word of the system data bus on the system clock while an active-low enable is held. Two of its bits come out as dedicated controls: one enables check-bit injection for diagnostics and one selects the read-write-back data routing. A packed 38-bit status word is available as a port. A read-back multiplexer presents the status word, the captured data word and the mode register as 32-bit words chosen by a select code.

All inputs are sampled on every clock edge, with no valid/ready handshake. The producer has no way to hold data back, so the block never applies back-pressure, and every sampled edge counts.

Top module: `edc_err_log`

## Requirements
- R1: When the syndrome-domain reset is low, the count, every captured field, the running syndrome and the captured data word are cleared and capture is re-armed. When the system-domain reset is low, the mode register is cleared.
- R2: On each syndrome clock edge with err_flag high and diag_clr low, the error count rises by exactly one, unless it is already 15.
- R3: The error count saturates. Once it reaches 15 it stays at 15 through further errors until the next clear.
- R4: The first edge with err_flag high after a clear captures the check bits, the syndrome, the full data word and a 2-bit error type. The type is 01 when multi_err is low and 11 when multi_err is high.
- R5: After the first capture, the captured check bits, syndrome, type and data word do not change on later errors until diag_clr.
- R6: The running syndrome register loads the syndrome input on every syndrome clock edge without diag_clr, whether or not err_flag is high.
- R7: diag_clr is synchronous to the syndrome clock and takes priority over an error on the same edge. It zeroes the count, the captured fields and the running syndrome, and re-arms capture.
- R8: The status word holds the captured check bits in bits 7:0 and the captured syndrome in bits 15:8. Bits 23:16 read as zero. The count is in bits 27:24, the captured type in bits 29:28 and the running syndrome in bits 37:30.
- R9: On a rising system clock edge with mode_en_n low, the mode register loads sys_data_lo. With mode_en_n high it holds its value. inj_mode is mode bit 2 and wb_route is mode bit 4.
- R10: rd_data returns a word selected by rd_sel. Code 0 gives status bits 31:0. Code 1 gives status bits 37:32, zero-extended. Code 2 gives data bits 31:0 and code 3 gives data bits 63:32. Code 4 gives the zero-extended mode register. Codes 5 to 7 give zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| syn_clk | input | 1 | Diagnostic (syndrome) clock |
| syn_rst_n | input | 1 | Synchronous active-low reset, syndrome domain |
| diag_clr | input | 1 | Synchronous diagnostic clear |
| err_flag | input | 1 | Error reported by the correction unit |
| multi_err | input | 1 | Multiple-bit error reported |
| syndrome | input | 8 | Syndrome from the correction unit |
| chk_bits | input | 8 | Check bits from the correction unit |
| data_word | input | 64 | Read data word |
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Synchronous active-low reset, system domain |
| mode_en_n | input | 1 | Active-low mode register load enable |
| sys_data_lo | input | 16 | Low half-word of the system data bus |
| rd_sel | input | 3 | Read-back word select |
| status | output | 38 | Packed status word |
| cap_data | output | 64 | Captured first-error data word |
| mode_q | output | 16 | Mode register |
| inj_mode | output | 1 | Check-bit injection control |
| wb_route | output | 1 | Read-write-back routing control |
| rd_data | output | 32 | Read-back word |

## Verification
The bench runs the count past fifteen. A counter that wraps would show zero or one where fifteen is expected. It sends errors of a different type, syndrome and data after the first one. A snapshot that re-captured would show the later error's fields, while a running syndrome that only loaded on errors would lag on error-free edges. It asserts a clear on the same edge as an error, which catches a clear that loses priority and leaves the count at one or captures that error. Finally it drives mode data with the enable high to expose a register that loads regardless, and it walks every select code, including the unused ones, to catch a shifted or mis-padded read-back field.

// File: rtl/edc_log_pkg.sv
package edc_log_pkg;

  typedef enum logic [1:0] {
    ET_NONE   = 2'b00,
    ET_SINGLE = 2'b01,
    ET_MULTI  = 2'b11
  } err_kind_t;

  function automatic err_kind_t classify(input logic err, input logic multi);
    if (!err)      return ET_NONE;
    else if (multi) return ET_MULTI;
    else            return ET_SINGLE;
  endfunction

endpackage

// File: rtl/edc_sat_counter.sv
module edc_sat_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n || clr)             count <= '0;
    else if (inc && count != TOP)  count <= count + 1'b1;
  end
endmodule

// File: rtl/edc_first_snap.sv
module edc_first_snap
  import edc_log_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CB_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              hit,
  input  err_kind_t         kind,
  input  logic [CB_W-1:0]   syn_in,
  input  logic [CB_W-1:0]   chk_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              taken,
  output logic [CB_W-1:0]   cap_syn,
  output logic [CB_W-1:0]   cap_chk,
  output err_kind_t         cap_kind,
  output logic [DATA_W-1:0] cap_data,
  output logic [CB_W-1:0]   run_syn
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      taken    <= 1'b0;
      cap_syn  <= '0;
      cap_chk  <= '0;
      cap_kind <= ET_NONE;
      cap_data <= '0;
      run_syn  <= '0;
    end else begin
      run_syn <= syn_in;
      if (hit && !taken) begin
        taken    <= 1'b1;
        cap_syn  <= syn_in;
        cap_chk  <= chk_in;
        cap_kind <= kind;
        cap_data <= data_in;
      end
    end
  end
endmodule

// File: rtl/edc_mode_reg.sv
module edc_mode_reg #(
  parameter int W       = 16,
  parameter int INJ_BIT = 2,
  parameter int WB_BIT  = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         inj,
  output logic         wb
);
  always_ff @(posedge clk) begin
    if (!rst_n)       q <= '0;
    else if (!load_n) q <= d;
  end

  assign inj = q[INJ_BIT];
  assign wb  = q[WB_BIT];
endmodule

// File: rtl/edc_err_log.sv
module edc_err_log
  import edc_log_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CB_W   = 8,
  parameter int CNT_W  = 4,
  parameter int RSV_W  = 8,
  parameter int MODE_W = 16,
  parameter int RD_W   = 32,
  parameter int SEL_W  = 3,
  localparam int STAT_W = 3 * CB_W + RSV_W + CNT_W + 2
) (
  input  logic              syn_clk,
  input  logic              syn_rst_n,
  input  logic              diag_clr,
  input  logic              err_flag,
  input  logic              multi_err,
  input  logic [CB_W-1:0]   syndrome,
  input  logic [CB_W-1:0]   chk_bits,
  input  logic [DATA_W-1:0] data_word,
  input  logic              sys_clk,
  input  logic              sys_rst_n,
  input  logic              mode_en_n,
  input  logic [MODE_W-1:0] sys_data_lo,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [STAT_W-1:0] status,
  output logic [DATA_W-1:0] cap_data,
  output logic [MODE_W-1:0] mode_q,
  output logic              inj_mode,
  output logic              wb_route,
  output logic [RD_W-1:0]   rd_data
);
  localparam int STAT_WORDS = (STAT_W + RD_W - 1) / RD_W;
  localparam int DATA_WORDS = DATA_W / RD_W;
  localparam int NWORDS     = STAT_WORDS + DATA_WORDS + 1;

  logic [CNT_W-1:0] err_cnt;
  logic             snap_taken;
  logic [CB_W-1:0]  cap_syn, cap_chk, run_syn;
  err_kind_t        cap_kind;

  edc_sat_counter #(.W(CNT_W)) u_cnt (
    .clk(syn_clk), .rst_n(syn_rst_n), .clr(diag_clr),
    .inc(err_flag), .count(err_cnt)
  );

  edc_first_snap #(.DATA_W(DATA_W), .CB_W(CB_W)) u_snap (
    .clk(syn_clk), .rst_n(syn_rst_n), .clr(diag_clr),
    .hit(err_flag), .kind(classify(err_flag, multi_err)),
    .syn_in(syndrome), .chk_in(chk_bits), .data_in(data_word),
    .taken(snap_taken), .cap_syn(cap_syn), .cap_chk(cap_chk),
    .cap_kind(cap_kind), .cap_data(cap_data), .run_syn(run_syn)
  );

  edc_mode_reg #(.W(MODE_W), .INJ_BIT(2), .WB_BIT(4)) u_mode (
    .clk(sys_clk), .rst_n(sys_rst_n), .load_n(mode_en_n),
    .d(sys_data_lo), .q(mode_q), .inj(inj_mode), .wb(wb_route)
  );

  assign status = {run_syn, logic'(cap_kind[1]), logic'(cap_kind[0]),
                   err_cnt, {RSV_W{1'b0}}, cap_syn, cap_chk};

  // read-back word table
  logic [STAT_WORDS*RD_W-1:0] stat_pad;
  logic [RD_W-1:0]            words [NWORDS];

  assign stat_pad = {{(STAT_WORDS*RD_W-STAT_W){1'b0}}, status};

  genvar gi;
  generate
    for (gi = 0; gi < STAT_WORDS; gi++) begin : g_stat
      assign words[gi] = stat_pad[gi*RD_W +: RD_W];
    end
    for (gi = 0; gi < DATA_WORDS; gi++) begin : g_data
      assign words[STAT_WORDS+gi] = cap_data[gi*RD_W +: RD_W];
    end
  endgenerate
  assign words[NWORDS-1] = {{(RD_W-MODE_W){1'b0}}, mode_q};

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NWORDS; i++)
      if (rd_sel == SEL_W'(i)) rd_data = words[i];
  end
endmodule

// File: rtl/edc_err_log_chk.sv
module edc_err_log_chk #(
  parameter int DATA_W = 64,
  parameter int CB_W   = 8,
  parameter int CNT_W  = 4,
  parameter int RSV_W  = 8,
  parameter int MODE_W = 16,
  localparam int STAT_W = 3 * CB_W + RSV_W + CNT_W + 2
) (
  input logic              syn_clk,
  input logic              syn_rst_n,
  input logic              diag_clr,
  input logic              err_flag,
  input logic [CB_W-1:0]   syndrome,
  input logic [STAT_W-1:0] status,
  input logic [DATA_W-1:0] cap_data,
  input logic              taken,
  input logic              sys_clk,
  input logic              sys_rst_n,
  input logic              mode_en_n,
  input logic [MODE_W-1:0] sys_data_lo,
  input logic [MODE_W-1:0] mode_q
);
  localparam int CNT_LO = 2 * CB_W + RSV_W;
  localparam int RUN_LO = CNT_LO + CNT_W + 2;
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0]  cnt;
  logic [CB_W-1:0]   run;
  logic [CNT_LO-1:0] frozen_lo;
  logic [1:0]        kind;
  assign cnt       = status[CNT_LO +: CNT_W];
  assign run       = status[RUN_LO +: CB_W];
  assign frozen_lo = status[CNT_LO-1:0];
  assign kind      = status[CNT_LO+CNT_W +: 2];

  // R2
  cnt_step_chk: assert property (@(posedge syn_clk) disable iff (!syn_rst_n)
    (err_flag && !diag_clr && cnt != TOP) |=> cnt == $past(cnt) + 1'b1);

  // R3
  cnt_sat_chk: assert property (@(posedge syn_clk) disable iff (!syn_rst_n)
    (cnt == TOP && !diag_clr) |=> cnt == TOP);

  // R5
  snap_frozen_chk: assert property (@(posedge syn_clk) disable iff (!syn_rst_n)
    (taken && !diag_clr) |=> ($stable(cap_data) && $stable(frozen_lo) && $stable(kind)));

  // R6
  run_syn_chk: assert property (@(posedge syn_clk) disable iff (!syn_rst_n)
    !diag_clr |=> run == $past(syndrome));

  // R7
  clear_chk: assert property (@(posedge syn_clk) disable iff (!syn_rst_n)
    diag_clr |=> (cnt == '0 && !taken && run == '0 && cap_data == '0));

  // R9
  mode_load_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    !mode_en_n |=> mode_q == $past(sys_data_lo));

  // R9
  mode_hold_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    mode_en_n |=> $stable(mode_q));
endmodule

bind edc_err_log edc_err_log_chk #(
  .DATA_W(DATA_W), .CB_W(CB_W), .CNT_W(CNT_W), .RSV_W(RSV_W), .MODE_W(MODE_W)
) u_chk (
  .syn_clk(syn_clk), .syn_rst_n(syn_rst_n), .diag_clr(diag_clr),
  .err_flag(err_flag), .syndrome(syndrome), .status(status),
  .cap_data(cap_data), .taken(snap_taken), .sys_clk(sys_clk),
  .sys_rst_n(sys_rst_n), .mode_en_n(mode_en_n), .sys_data_lo(sys_data_lo),
  .mode_q(mode_q)
);

// File: tb/edc_err_log_tb.sv
`timescale 1ns/1ps
module edc_err_log_tb;
  logic        syn_clk = 0, sys_clk = 0;
  logic        syn_rst_n = 0, sys_rst_n = 0;
  logic        diag_clr = 0, err_flag = 0, multi_err = 0;
  logic [7:0]  syndrome = 0, chk_bits = 0;
  logic [63:0] data_word = 0;
  logic        mode_en_n = 1;
  logic [15:0] sys_data_lo = 0;
  logic [2:0]  rd_sel = 0;
  logic [37:0] status;
  logic [63:0] cap_data;
  logic [15:0] mode_q;
  logic        inj_mode, wb_route;
  logic [31:0] rd_data;

  always #2.5 syn_clk = ~syn_clk;
  always #2.5 sys_clk = ~sys_clk;

  edc_err_log u_dut (
    .syn_clk(syn_clk), .syn_rst_n(syn_rst_n), .diag_clr(diag_clr),
    .err_flag(err_flag), .multi_err(multi_err), .syndrome(syndrome),
    .chk_bits(chk_bits), .data_word(data_word), .sys_clk(sys_clk),
    .sys_rst_n(sys_rst_n), .mode_en_n(mode_en_n), .sys_data_lo(sys_data_lo),
    .rd_sel(rd_sel), .status(status), .cap_data(cap_data), .mode_q(mode_q),
    .inj_mode(inj_mode), .wb_route(wb_route), .rd_data(rd_data)
  );

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // reference model
  logic [3:0]  m_cnt = 0;
  bit          m_taken = 0;
  logic [7:0]  m_cb = 0, m_syn = 0, m_run = 0;
  logic [1:0]  m_type = 0;
  logic [63:0] m_data = 0;
  logic [15:0] m_mode = 0;

  function automatic logic [37:0] exp_status();
    return {m_run, m_type, m_cnt, 8'h00, m_syn, m_cb};
  endfunction

  typedef struct { logic [37:0] st; logic [63:0] dat; string req; } item_t;
  item_t sb_q[$];

  task automatic syn_step(input logic e, input logic m, input logic [7:0] s,
                          input logic [7:0] cb, input logic [63:0] d,
                          input logic c, input string req);
    item_t it;
    @(negedge syn_clk);
    err_flag = e; multi_err = m; syndrome = s; chk_bits = cb; data_word = d; diag_clr = c;
    @(posedge syn_clk);
    if (c) begin
      m_cnt = 0; m_taken = 0; m_cb = 0; m_syn = 0; m_run = 0; m_type = 0; m_data = 0;
    end else begin
      m_run = s;
      if (e && m_cnt != 4'hF) m_cnt = m_cnt + 1;
      if (e && !m_taken) begin
        m_taken = 1; m_cb = cb; m_syn = s; m_data = d;
        m_type = m ? 2'b11 : 2'b01;
      end
    end
    it.st = exp_status(); it.dat = m_data; it.req = req;
    sb_q.push_back(it);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge syn_clk);
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check(status == it.st, {it.req, " status"}, 64'(status), 64'(it.st));
        check(cap_data == it.dat, {it.req, " data"}, cap_data, it.dat);
      end
    end
  end

  task automatic mode_step(input logic en_n, input logic [15:0] v, input string req);
    @(negedge sys_clk);
    mode_en_n = en_n; sys_data_lo = v;
    @(posedge sys_clk);
    if (!en_n) m_mode = v;
    @(negedge sys_clk);
    mode_en_n = 1'b1;
    check(mode_q == m_mode, req, 64'(mode_q), 64'(m_mode));
    check(inj_mode == m_mode[2], {req, " inj"}, 64'(inj_mode), 64'(m_mode[2]));
    check(wb_route == m_mode[4], {req, " wb"}, 64'(wb_route), 64'(m_mode[4]));
  endtask

  task automatic settle();
    while (sb_q.size() > 0) @(posedge syn_clk);
    @(negedge syn_clk);
  endtask

  initial begin
    repeat (3) @(posedge syn_clk);
    @(negedge syn_clk);
    syn_rst_n = 1; sys_rst_n = 1;
    #1;
    // R1 reset state
    check(status == '0, "R1 status", 64'(status), 64'h0);
    check(cap_data == '0, "R1 data", cap_data, 64'h0);
    check(mode_q == '0, "R1 mode", 64'(mode_q), 64'h0);

    // R6 running syndrome on an error-free edge
    syn_step(0, 0, 8'h3C, 8'h11, 64'h1, 0, "R6 no-error load");
    // R4 first error capture, single type
    syn_step(1, 0, 8'h15, 8'hA5, 64'hDEAD_BEEF_0123_4567, 0, "R4 first capture");
    // R5 later errors leave snapshot frozen, R6 running follows
    syn_step(1, 1, 8'h72, 8'h5A, 64'h0BAD_F00D_CAFE_1234, 0, "R5 frozen R6 follow");
    syn_step(0, 0, 8'h99, 8'h00, 64'hFFFF_0000_FFFF_0000, 0, "R6 follow idle");
    // R2 count steps, R3 saturation
    for (int i = 0; i < 13; i++)
      syn_step(1, i[0], 8'(i + 8'h40), 8'(i), 64'(i), 0, "R2 count step");
    syn_step(1, 0, 8'hE1, 8'h22, 64'h5, 0, "R3 saturate at 15");
    syn_step(1, 1, 8'hE2, 8'h23, 64'h6, 0, "R3 hold at 15");
    settle();
    check(status[27:24] == 4'hF, "R3 count field", 64'(status[27:24]), 64'hF);
    check(status[23:16] == 8'h00, "R8 reserved zero", 64'(status[23:16]), 64'h0);
    // R7 clear wins over simultaneous error
    syn_step(1, 1, 8'h77, 8'h66, 64'h1234, 1, "R7 clear priority");
    syn_step(0, 0, 8'h00, 8'h00, 64'h0, 0, "R7 after clear");
    // R4 rearmed, multiple type
    syn_step(1, 1, 8'hC3, 8'h3C, 64'h8000_0000_0000_0001, 0, "R4 multi capture");
    syn_step(0, 0, 8'h5E, 8'h00, 64'h0, 0, "R8 layout");
    settle();
    check(status[29:28] == 2'b11, "R4 type field", 64'(status[29:28]), 64'h3);
    check(status[37:30] == 8'h5E, "R8 running field", 64'(status[37:30]), 64'h5E);

    // R9 mode register
    mode_step(0, 16'h0014, "R9 load");
    mode_step(1, 16'hFFEB, "R9 hold when disabled");
    mode_step(0, 16'hA5C3, "R9 reload");

    // R10 read-back
    for (int s = 0; s < 8; s++) begin
      logic [37:0] st;
      logic [31:0] exp;
      st = exp_status();
      case (s)
        0: exp = st[31:0];
        1: exp = {26'h0, st[37:32]};
        2: exp = m_data[31:0];
        3: exp = m_data[63:32];
        4: exp = {16'h0, m_mode};
        default: exp = '0;
      endcase
      @(negedge syn_clk);
      rd_sel = 3'(s);
      #1;
      check(rd_data == exp, $sformatf("R10 sel %0d", s), 64'(rd_data), 64'(exp));
    end

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule